// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer Channel

This block is a single channel of an interval timer. Software writes a 32-bit word that holds a 24-bit interval and a force-load flag. The channel counts down from the interval minus one, one step per clock. When the count reaches zero it raises a sticky interrupt flag. In one-shot mode it then goes idle. In repeat mode it reloads the most recent interval and keeps counting.

The write decides what the channel does next. The outcome depends on whether the interval is zero, whether the force-load flag is set, and whether the channel is already counting. A write can start the channel, restart it at once, queue a new interval for the next period, stop it at once, or let the current period finish and then stop. The present count, the running state and the stored interval can be read on every cycle.

Top module: `ival_timer`

## Requirements
- R1: Bits 23:0 of the written word are the interval and bit 31 is the force-load flag. `ival_o` returns the stored interval with bit 31 always 0. The stored interval is 0 after reset.
- R2: A nonzero interval N written while idle sets `running_o` after the write edge, and `count_o` becomes N-1.
- R3: While running with no write, `count_o` decreases by exactly one on each clock until it reaches zero.
- R4: In one-shot mode (`repeat_i`=0), a clock edge seen with the count at zero while running sets `irq_o` and clears `running_o`. The count stays at 0.
- R5: In repeat mode (`repeat_i`=1), a clock edge at count zero with a nonzero stored interval sets `irq_o` and loads interval-1 on that edge. The interval used is the latest one, including a value written on that same edge.
- R6: A nonzero write with force-load clear while running leaves the count running undisturbed. Only the stored interval changes.
- R7: A nonzero write N with force-load set while running loads N-1 into the count on that edge.
- R8: A zero write with force-load set while running clears `running_o` and `count_o` on that edge.
- R9: A zero write with force-load clear while running lets the count reach zero, raise `irq_o`, and then go idle, even in repeat mode.
- R10: `irq_o` stays set until an `irq_clr_i` pulse arrives. If a clear and an expiry fall on the same edge, `irq_o` stays set.
- R11: A zero write while idle leaves `running_o` low and `count_o` at 0.
- R12: After asynchronous reset, `count_o`, `running_o`, `irq_o` and `ival_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the interval word |
| wr_data_i | input | 32 | Interval in bits 23:0, force-load flag in bit 31 |
| repeat_i | input | 1 | 1 selects repeat mode, 0 selects one-shot mode |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ival_o | output | 32 | Stored interval, with bit 31 read as 0 |
| count_o | output | 24 | Present count |
| running_o | output | 1 | High while the channel is counting |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of events can land on the same edge. The first pair is an expiry and an interrupt clear. The bench times `irq_clr_i` to arrive exactly when a repeat-mode count reaches zero, and it expects the flag to stay high and the count to reload. The second pair is an expiry and a non-forced interval write. The bench writes a new interval on the edge where the count is zero, and it expects the reload to use the new value, not the old one.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IVAL_W  = 24;
  localparam int unsigned FORCE_B = 31;

  typedef struct packed {
    logic              load;    // copy ld_val into count now
    logic              halt;    // stop at once
    logic [IVAL_W-1:0] ld_val;  // interval minus one
  } wr_ctl_t;
endpackage

// File: rtl/ival_wr_decode.sv
module ival_wr_decode
  import ival_timer_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              running_i,
  output wr_ctl_t           ctl_o,
  output logic [IVAL_W-1:0] ival_wr_o
);
  logic [IVAL_W-1:0] val;
  logic              frc;
  logic              nz;

  assign val       = wr_data_i[IVAL_W-1:0];
  assign frc       = wr_data_i[FORCE_B];
  assign nz        = |val;
  assign ival_wr_o = val;

  always_comb begin
    ctl_o        = '0;
    ctl_o.ld_val = val - 1'b1;
    if (wr_en_i) begin
      if (!running_i) ctl_o.load = nz;
      else if (frc) begin
        ctl_o.load = nz;
        ctl_o.halt = !nz;
      end
    end
  end
endmodule

// File: rtl/ival_down_cnt.sv
module ival_down_cnt
  import ival_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_ctl_t           ctl_i,
  input  logic              repeat_i,
  input  logic [IVAL_W-1:0] ival_next_i,
  output logic [IVAL_W-1:0] count_o,
  output logic              running_o,
  output logic              expire_o
);
  logic [IVAL_W-1:0] cnt_q;
  logic              run_q;

  assign expire_o  = run_q && (cnt_q == '0);
  assign count_o   = cnt_q;
  assign running_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ctl_i.halt) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ctl_i.load) begin
      cnt_q <= ctl_i.ld_val;
      run_q <= 1'b1;
    end else if (expire_o) begin
      if (repeat_i && (ival_next_i != '0)) cnt_q <= ival_next_i - 1'b1;
      else run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ival_irq_flag.sv
module ival_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;  // set wins over clear
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        repeat_i,
  input  logic        irq_clr_i,
  output logic [31:0] ival_o,
  output logic [23:0] count_o,
  output logic        running_o,
  output logic        irq_o
);
  wr_ctl_t           ctl;
  logic [IVAL_W-1:0] ival_q;
  logic [IVAL_W-1:0] ival_wr;
  logic [IVAL_W-1:0] ival_next;
  logic              expire;

  assign ival_next = wr_en_i ? ival_wr : ival_q;
  assign ival_o    = {{(DATA_W-IVAL_W){1'b0}}, ival_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ival_q <= '0;
    else         ival_q <= ival_next;
  end

  ival_wr_decode u_dec (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .running_i (running_o),
    .ctl_o     (ctl),
    .ival_wr_o (ival_wr)
  );

  ival_down_cnt u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .repeat_i    (repeat_i),
    .ival_next_i (ival_next),
    .count_o     (count_o),
    .running_o   (running_o),
    .expire_o    (expire)
  );

  ival_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        repeat_i,
  input logic        irq_clr_i,
  input logic [31:0] ival_o,
  input logic [23:0] count_o,
  input logic        running_o,
  input logic        irq_o
);
  logic at_zero;
  assign at_zero = running_o && (count_o == 24'd0);

  // R1
  force_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ival_o[31] == 1'b0);

  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !running_o && (wr_data_i[23:0] != 24'd0)
    |=> running_o && (count_o == $past(wr_data_i[23:0]) - 24'd1));

  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && (count_o != 24'd0) && !wr_en_i
    |=> count_o == $past(count_o) - 24'd1);

  // R4
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_zero && !repeat_i && !wr_en_i |=> !running_o);

  // R8
  force_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && running_o && wr_data_i[31] && (wr_data_i[23:0] == 24'd0)
    |=> !running_o && (count_o == 24'd0));

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_zero |=> irq_o);

  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !at_zero |=> !irq_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !(wr_en_i && (wr_data_i[23:0] != 24'd0)) |=> !running_o);
endmodule

bind ival_timer ival_timer_chk u_chk (.*);

// File: tb/sim_ival_timer.sv
module sim_ival_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rpt = 1'b0;
  logic        clr = 1'b0;
  logic [31:0] ival;
  logic [23:0] count;
  logic        running;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  ival_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .repeat_i(rpt), .irq_clr_i(clr), .ival_o(ival), .count_o(count),
    .running_o(running), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic        rp;
    logic        cl;
    logic [23:0] cnt;
    logic        run;
    logic        irq;
  } vec_t;

  // per cycle: inputs, then outputs expected after that edge
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd3,          1'b0, 1'b0, 24'd2, 1'b1, 1'b0}, // R2
    '{1'b0, 32'd0,          1'b0, 1'b0, 24'd1, 1'b1, 1'b0}, // R3
    '{1'b0, 32'd0,          1'b0, 1'b0, 24'd0, 1'b1, 1'b0}, // R3
    '{1'b0, 32'd0,          1'b0, 1'b0, 24'd0, 1'b0, 1'b1}, // R4
    '{1'b0, 32'd0,          1'b0, 1'b1, 24'd0, 1'b0, 1'b0}, // R10
    '{1'b0, 32'd0,          1'b0, 1'b0, 24'd0, 1'b0, 1'b0},
    '{1'b1, 32'd2,          1'b1, 1'b0, 24'd1, 1'b1, 1'b0}, // R2
    '{1'b0, 32'd0,          1'b1, 1'b0, 24'd0, 1'b1, 1'b0},
    '{1'b0, 32'd0,          1'b1, 1'b0, 24'd1, 1'b1, 1'b1}, // R5
    '{1'b0, 32'd0,          1'b1, 1'b1, 24'd0, 1'b1, 1'b0}, // R10
    '{1'b1, 32'd5,          1'b1, 1'b0, 24'd4, 1'b1, 1'b1}, // R5 same-edge write
    '{1'b1, 32'd7,          1'b1, 1'b0, 24'd3, 1'b1, 1'b1}, // R6
    '{1'b1, 32'h8000_0002,  1'b1, 1'b0, 24'd1, 1'b1, 1'b1}, // R7
    '{1'b0, 32'd0,          1'b1, 1'b1, 24'd0, 1'b1, 1'b0},
    '{1'b0, 32'd0,          1'b1, 1'b1, 24'd1, 1'b1, 1'b1}, // R10 clear+expiry
    '{1'b1, 32'd0,          1'b1, 1'b0, 24'd0, 1'b1, 1'b1}, // R9
    '{1'b0, 32'd0,          1'b1, 1'b0, 24'd0, 1'b0, 1'b1}, // R9
    '{1'b0, 32'd0,          1'b1, 1'b1, 24'd0, 1'b0, 1'b0},
    '{1'b1, 32'd4,          1'b1, 1'b0, 24'd3, 1'b1, 1'b0},
    '{1'b1, 32'h8000_0000,  1'b1, 1'b0, 24'd0, 1'b0, 1'b0}, // R8
    '{1'b1, 32'd0,          1'b1, 1'b0, 24'd0, 1'b0, 1'b0}, // R11
    '{1'b0, 32'd0,          1'b1, 1'b0, 24'd0, 1'b0, 1'b0}  // R11
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req, logic [23:0] c, logic r, logic i);
    check({req, " count"}, {8'd0, count}, {8'd0, c});
    check({req, " running"}, {31'd0, running}, {31'd0, r});
    check({req, " irq"}, {31'd0, irq}, {31'd0, i});
  endtask

  initial begin
    #10000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_state("R12 reset", 24'd0, 1'b0, 1'b0);
    check("R12 ival", ival, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i].wr; wr_data = VECS[i].data;
      rpt = VECS[i].rp; clr = VECS[i].cl;
      @(negedge clk);
      check_state($sformatf("vec%0d R2-R11", i), VECS[i].cnt, VECS[i].run, VECS[i].irq);
    end
    wr_en = 1'b0; clr = 1'b0;
    check("R1 ival after zero", ival, 32'd0);

    // R1: force bit not stored; field readback
    wr_en = 1'b1; wr_data = 32'h80AB_CDEF; rpt = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R1 ival field", ival, 32'h00AB_CDEF);
    check("R2 big count", {8'd0, count}, 32'h00AB_CDEE);
    @(negedge clk);
    check("R3 big dec", {8'd0, count}, 32'h00AB_CDED);

    // R7: force reload to 1 -> count 0, then one-shot expiry
    wr_en = 1'b1; wr_data = 32'h8000_0001;
    @(negedge clk);
    wr_en = 1'b0;
    check_state("R7 force to 1", 24'd0, 1'b1, 1'b0);
    @(negedge clk);
    check_state("R4 expiry", 24'd0, 1'b0, 1'b1);

    // R12: reset while running
    wr_en = 1'b1; wr_data = 32'd9;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    check_state("R12 mid-run reset", 24'd0, 1'b0, 1'b0);
    check("R12 ival mid-run", ival, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R11 idle after reset", 24'd0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule